// File: doc/BRIEF.md
# Arithmetic unit with stored flags and branch test

This block combines a combinational two-operand arithmetic/logic unit with a three-bit register of condition flags and a branch-condition evaluator. The operands are named X (first source register) and Y (second source register, which is also the destination). A two-bit operation code selects one of four operations. The result appears on the output in the same cycle.

When the flag-write enable is high at a rising clock edge, the overflow, zero and sign flags computed from the current operation are captured. A three-bit branch code is evaluated against the captured flags, not the live ones, and drives a taken output. A processor core uses the result for register write-back, raises the enable only for arithmetic and logic instructions, and uses the taken output to steer conditional jumps.

Top module: `alu_cond_unit`

## Requirements
- R1: Operation code 0 drives result = X + Y, truncated to WIDTH bits.
- R2: Operation code 1 drives result = Y - X, truncated to WIDTH bits, so the operand order is reversed.
- R3: Operation code 2 drives the bitwise AND of X and Y, and code 3 drives the bitwise XOR.
- R4: After a flag load, the zero flag is 1 exactly when the loaded result was all zeros, and the sign flag equals the result's top bit.
- R5: The loaded overflow flag is set for code 0 when X and Y have the same sign and the sum's sign differs from it. It is set for code 1 when X and Y differ in sign and the difference's sign differs from Y's sign. It is 0 for codes 2 and 3.
- R6: The flags change only at a rising edge where the flag-write enable is 1; with the enable at 0 they hold.
- R7: A synchronous reset sets zero=1, sign=0, overflow=0.
- R8: With L = sign XOR overflow, branch code 0 is always taken, code 1 is taken when L or zero, code 2 when L, and code 3 when zero.
- R9: Branch code 4 is taken when zero is 0, code 5 when L is 0, and code 6 when both L and zero are 0.
- R10: Branch code 7 is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_fn | input | 2 | Operation: 0 add, 1 subtract, 2 AND, 3 XOR |
| op_x | input | WIDTH | Operand X |
| op_y | input | WIDTH | Operand Y |
| result | output | WIDTH | Combinational operation result |
| cc_we | input | 1 | Flag-write enable |
| jmp_fn | input | 3 | Branch condition code |
| take | output | 1 | Branch condition holds for the stored flags |
| cc_zf | output | 1 | Stored zero flag |
| cc_sf | output | 1 | Stored sign flag |
| cc_of | output | 1 | Stored overflow flag |

## Verification
The bench builds a 4-bit instance and applies every operand pair under every operation. After each flag load it checks all eight branch codes, so each sign and overflow combination is reached. Subtraction with the most negative value catches a design that computes X - Y, which would give a wrong result and a flipped sign. It also catches a design that tests overflow against X's sign instead of Y's, which would give a wrong overflow flag. An overflow check that ignores the operand signs shows up as a taken less-than on non-overflowing sums. A design that leaves stale overflow after AND/XOR shows up in the greater/less branches. Loads with the enable low catch a design whose flags follow the live ALU output.

// File: rtl/alu_cond_unit.sv
`timescale 1ns/1ps
module alu_cond_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       alu_fn,
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  output logic [WIDTH-1:0] result,
  input  logic             cc_we,
  input  logic [2:0]       jmp_fn,
  output logic             take,
  output logic             cc_zf,
  output logic             cc_sf,
  output logic             cc_of
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] sum_w, dif_w;
  logic         ovf_w, lt_w;

  assign sum_w = op_x + op_y;
  assign dif_w = op_y - op_x;

  always_comb begin
    case (alu_fn)
      2'd0:    result = sum_w;
      2'd1:    result = dif_w;
      2'd2:    result = op_x & op_y;
      default: result = op_x ^ op_y;
    endcase
  end

  always_comb begin
    case (alu_fn)
      2'd0:    ovf_w = (op_x[MSB] == op_y[MSB]) && (sum_w[MSB] != op_x[MSB]);
      2'd1:    ovf_w = (op_x[MSB] != op_y[MSB]) && (dif_w[MSB] != op_y[MSB]);
      default: ovf_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_zf <= 1'b1;
      cc_sf <= 1'b0;
      cc_of <= 1'b0;
    end else if (cc_we) begin
      cc_zf <= (result == '0);
      cc_sf <= result[MSB];
      cc_of <= ovf_w;
    end
  end

  assign lt_w = cc_sf ^ cc_of;

  always_comb begin
    case (jmp_fn)
      3'd0:    take = 1'b1;
      3'd1:    take = lt_w | cc_zf;
      3'd2:    take = lt_w;
      3'd3:    take = cc_zf;
      3'd4:    take = !cc_zf;
      3'd5:    take = !lt_w;
      3'd6:    take = !lt_w && !cc_zf;
      default: take = 1'b0;
    endcase
  end

  a_r7_reset_flags: assert property (@(posedge clk)
    rst |=> cc_zf && !cc_sf && !cc_of);

  a_r6_hold_flags: assert property (@(posedge clk) disable iff (rst)
    !cc_we |=> $stable({cc_zf, cc_sf, cc_of}));

  a_r4_zero_load: assert property (@(posedge clk) disable iff (rst)
    cc_we |=> cc_zf == ($past(result) == '0));

  a_r5_logic_no_ovf: assert property (@(posedge clk) disable iff (rst)
    cc_we && alu_fn[1] |=> !cc_of);

  a_r8_always_taken: assert property (@(posedge clk) disable iff (rst)
    jmp_fn == 3'd0 |-> take);

  a_r9_ne_taken: assert property (@(posedge clk) disable iff (rst)
    jmp_fn == 3'd4 |-> take != cc_zf);

  a_r10_never_taken: assert property (@(posedge clk) disable iff (rst)
    jmp_fn == 3'd7 |-> !take);
endmodule

// File: tb/test_alu_cond_unit.sv
`timescale 1ns/1ps
module test_alu_cond_unit;
  localparam int CLK_P = 20;
  localparam int W     = 4;
  localparam int SPAN  = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   alu_fn = '0;
  logic [W-1:0] op_x = '0, op_y = '0;
  logic [W-1:0] result;
  logic         cc_we = 1'b0;
  logic [2:0]   jmp_fn = '0;
  logic         take, cc_zf, cc_sf, cc_of;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  alu_cond_unit #(.WIDTH(W)) i_alu_cond_unit (
    .clk(clk), .rst(rst), .alu_fn(alu_fn), .op_x(op_x), .op_y(op_y),
    .result(result), .cc_we(cc_we), .jmp_fn(jmp_fn), .take(take),
    .cc_zf(cc_zf), .cc_sf(cc_sf), .cc_of(cc_of)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (fn=%0d x=%0d y=%0d j=%0d)",
               req, act, exp, alu_fn, op_x, op_y, jmp_fn);
    end
  endtask

  function automatic int sval(input int v);
    return (v >= SPAN/2) ? v - SPAN : v;
  endfunction

  function automatic int exp_take(input int j, input int z, input int s, input int o);
    int l = s ^ o;
    case (j)
      0: return 1;
      1: return l | z;
      2: return l;
      3: return z;
      4: return 1 - z;
      5: return 1 - l;
      6: return (l == 0 && z == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check_branches(input int z, input int s, input int o);
    for (int j = 0; j < 8; j++) begin
      jmp_fn = j[2:0];
      #1;
      if (j == 7)      chk("R10", int'(take), 0);
      else if (j >= 4) chk("R9", int'(take), exp_take(j, z, s, o));
      else             chk("R8", int'(take), exp_take(j, z, s, o));
    end
  endtask

  initial begin
    int ez, es, eo;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R7", int'(cc_zf), 1);
    chk("R7", int'(cc_sf), 0);
    chk("R7", int'(cc_of), 0);
    check_branches(1, 0, 0);

    for (int f = 0; f < 4; f++) begin
      for (int x = 0; x < SPAN; x++) begin
        for (int y = 0; y < SPAN; y++) begin
          int er, t;
          @(negedge clk);
          alu_fn = f[1:0]; op_x = x[W-1:0]; op_y = y[W-1:0]; cc_we = 1'b1;
          #1;
          case (f)
            0: begin er = (x + y) % SPAN;        t = sval(x) + sval(y); end
            1: begin er = (y - x + SPAN) % SPAN; t = sval(y) - sval(x); end
            2: begin er = x & y;                 t = 0; end
            default: begin er = x ^ y;           t = 0; end
          endcase
          if (f == 0)      chk("R1", int'(result), er);
          else if (f == 1) chk("R2", int'(result), er);
          else             chk("R3", int'(result), er);
          eo = (f < 2 && (t > SPAN/2 - 1 || t < -SPAN/2)) ? 1 : 0;
          ez = (er == 0) ? 1 : 0;
          es = (er >= SPAN/2) ? 1 : 0;
          @(negedge clk);
          cc_we = 1'b0;
          #1;
          chk("R4", int'(cc_zf), ez);
          chk("R4", int'(cc_sf), es);
          chk("R5", int'(cc_of), eo);
          check_branches(ez, es, eo);
          // R6: new operands with enable low must not disturb stored flags
          op_x = W'(x + 5); op_y = W'(y + 9); alu_fn = 2'(f + 1);
          @(negedge clk);
          #1;
          chk("R6", int'({cc_zf, cc_sf, cc_of}), ez*4 + es*2 + eo);
        end
      end
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R7", int'({cc_zf, cc_sf, cc_of}), 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule